// File: doc/BRIEF.md
# Smart-Card Receiver with Parity Error Signalling

This block receives asynchronous characters on a single wire shared by a card and the host. Each character is a low start bit, eight data bits sent least significant bit first, an odd-parity bit and a high stop bit. Levels are taken as they are, without inversion. Every bit is sampled at its midpoint, using an enable tick that runs at sixteen times the bit rate. The byte and a parity-failure flag are placed in a receive buffer. A completion flag tells the host that a character has arrived.

When the error-signal enable is set and a character fails its parity check, the block pulls the shared wire low through an open-drain output. This tells the card to repeat the character. The wire stays low until the host reads the buffer. That read clears the parity-failure flag and the completion flag, and it releases the wire. While the wire is held low the receiver does not accept a new start bit. When the enable is clear, a failed character is only flagged.

Top module: `sc_rx_errsig`

## Requirements
- R1: The eight data bits of a character appear on `rd_data_o` with the first received data bit at bit 0. They are present from the clock edge at which the stop bit is sampled.
- R2: A start is detected on a tick that finds the synchronised line low. The start bit is checked 8 ticks later, and each later bit is sampled 16 ticks after the one before it, so only the middle of each bit period matters.
- R3: If the line is back high when the start bit is checked, the start is dropped as a glitch. Nothing is loaded and no flag changes.
- R4: Parity is odd. `par_err_o` is 1 after a character whose eight data bits plus the parity bit hold an even number of ones, and 0 otherwise.
- R5: `rx_done_o` becomes 1 at the stop-bit sample. A character with bad parity still loads its data into the buffer.
- R6: When `err_en_i` is 1 and the character has bad parity, `line_drv_low_o` becomes 1 at the same edge as the stop-bit sample.
- R7: When `err_en_i` is 0, a parity failure never asserts `line_drv_low_o`.
- R8: A one-cycle `rd_i` clears `rx_done_o`, `par_err_o` and `line_drv_low_o` at the next edge. The buffered byte is kept.
- R9: While `line_drv_low_o` is 1, no start bit is accepted, so the buffer and the flags stay unchanged.
- R10: After reset, every output is 0 and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Enable at 16x the bit rate |
| line_i | input | 1 | Level of the shared pulled-up wire |
| err_en_i | input | 1 | 1 = drive the wire low after a parity failure |
| rd_i | input | 1 | Buffer read strobe, one cycle |
| rd_data_o | output | 8 | Received byte |
| par_err_o | output | 1 | Parity failure of the buffered character |
| rx_done_o | output | 1 | Character received and not yet read |
| line_drv_low_o | output | 1 | Open-drain enable: 1 pulls the wire low |

## Verification
A change on the wire reaches the receiver two clocks later, through the synchroniser. The buffer, the flags and the drive output all change at the edge on which the stop-bit tick is taken, 168 ticks after start detection. A read takes effect at the very next edge. A behavioural reference counts ticks since start detection and runs in the same clock domain. It is compared with all four outputs at every falling edge, so each result is checked in the cycle it is due. Directed checks after each character and each read cover the good-parity and bad-parity cases with the enable set and with it cleared. They also cover a shortened start pulse and a character sent while the wire is held low.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // Odd parity: failure when the data bits plus the parity bit hold an even count of ones.
  function automatic logic parity_fails(input logic [7:0] data, input logic par);
    return ~(^{data, par});
  endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = d_i;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  // Idle level of the pulled-up wire is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
  import sc_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 line_s_i,
  input  logic                 hold_i,
  output logic                 load_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 par_o
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  rx_state_e            st_q, st_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 par_q, par_d;
  logic                 bit_end;

  assign bit_end = tick_i && (cnt_q == LAST_CNT);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    par_d  = par_q;
    load_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (tick_i && !hold_i && !line_s_i) begin
          st_d  = ST_START;
          cnt_d = '0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == MID_CNT) begin
            cnt_d = '0;
            bit_d = '0;
            st_d  = line_s_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          cnt_d = '0;
          sh_d  = {line_s_i, sh_q[DATA_BITS-1:1]};
          if (bit_q == LAST_BIT) st_d = ST_PAR;
          else                   bit_d = bit_q + 1'b1;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (bit_end) begin
          cnt_d = '0;
          par_d = line_s_i;
          st_d  = ST_STOP;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (bit_end) begin
          load_o = 1'b1;
          st_d   = ST_IDLE;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

  assign data_o = sh_q;
  assign par_o  = par_q;

  // R9: an idle receiver stays idle while the error signal holds the wire.
  p_hold_blocks_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && hold_i) |=> (st_q == ST_IDLE));

  // R3: a start bit found high at mid-bit returns the receiver to idle.
  p_glitch_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && tick_i && cnt_q == MID_CNT && line_s_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/sc_rx_buf.sv
module sc_rx_buf
  import sc_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 par_i,
  input  logic                 err_en_i,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 par_err_o,
  output logic                 done_o,
  output logic                 drv_low_o
);
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 perr_q, perr_d;
  logic                 done_q, done_d;
  logic                 drv_q, drv_d;
  logic                 bad;

  assign bad = parity_fails(data_i, par_i);

  // A load in the same cycle as a read takes priority.
  always_comb begin
    data_d = data_q;
    perr_d = perr_q;
    done_d = done_q;
    drv_d  = drv_q;
    if (rd_i) begin
      perr_d = 1'b0;
      done_d = 1'b0;
      drv_d  = 1'b0;
    end
    if (load_i) begin
      data_d = data_i;
      perr_d = bad;
      done_d = 1'b1;
      if (bad && err_en_i) drv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      perr_q <= 1'b0;
      done_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      perr_q <= perr_d;
      done_q <= done_d;
      drv_q  <= drv_d;
    end
  end

  assign data_o    = data_q;
  assign par_err_o = perr_q;
  assign done_o    = done_q;
  assign drv_low_o = drv_q;

  p_load_sets_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> done_o);

  p_drv_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_low_o |-> par_err_o);

  p_drv_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_low_o) |-> $past(err_en_i));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !load_i) |=> (!done_o && !par_err_o && !drv_low_o));
endmodule

// File: rtl/sc_rx_errsig.sv
module sc_rx_errsig #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic                 err_en_i,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 par_err_o,
  output logic                 rx_done_o,
  output logic                 line_drv_low_o
);
  logic                 line_s;
  logic                 load;
  logic [DATA_BITS-1:0] shift_data;
  logic                 shift_par;
  logic                 drv_low;

  sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d_i (line_i), .q_o (line_s)
  );

  sc_rx_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_frame (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .line_s_i (line_s),
    .hold_i (drv_low), .load_o (load), .data_o (shift_data), .par_o (shift_par)
  );

  sc_rx_buf #(.DATA_BITS(DATA_BITS)) u_buf (
    .clk (clk), .rst_n (rst_n), .load_i (load), .data_i (shift_data),
    .par_i (shift_par), .err_en_i (err_en_i), .rd_i (rd_i),
    .data_o (rd_data_o), .par_err_o (par_err_o), .done_o (rx_done_o),
    .drv_low_o (drv_low)
  );

  assign line_drv_low_o = drv_low;

  // R10: nothing is driven on the wire in the first cycle after reset.
  p_reset_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !line_drv_low_o);
endmodule

// File: tb/sim_sc_rx_errsig.sv
`timescale 1ns/1ps
module sim_sc_rx_errsig;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic card_drv;
  logic err_en;
  logic rd;
  logic [7:0] rd_data;
  logic par_err, rx_done, drv_low;
  wire  line = card_drv & ~drv_low;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int tdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_rx_errsig u0 (
    .clk (clk), .rst_n (rst_n), .tick_i (tick), .line_i (line),
    .err_en_i (err_en), .rd_i (rd), .rd_data_o (rd_data),
    .par_err_o (par_err), .rx_done_o (rx_done), .line_drv_low_o (drv_low)
  );

  always @(negedge clk) begin
    tick = (tdiv == TICK_DIV - 1);
    tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
  end

  // Behavioural reference: counts ticks since start detection.
  logic m_s0, m_s1, m_busy, m_drv, m_done, m_perr, m_par, m_load, ls;
  logic [7:0] m_bits, m_data;
  int m_t;

  always @(posedge clk or negedge rst_n) begin
    int k;
    if (!rst_n) begin
      m_s0 = 1; m_s1 = 1; m_busy = 0; m_drv = 0; m_done = 0; m_perr = 0;
      m_par = 0; m_bits = 0; m_data = 0; m_t = 0;
    end else begin
      ls = m_s1; m_s1 = m_s0; m_s0 = line;
      m_load = 0;
      if (tick) begin
        if (!m_busy) begin
          if (!m_drv && !ls) begin m_busy = 1; m_t = 0; end
        end else begin
          m_t++;
          if (m_t == 8) begin
            if (ls) m_busy = 0;
          end else if (m_t > 8 && (m_t - 8) % 16 == 0) begin
            k = (m_t - 8) / 16;
            if (k <= 8) m_bits[k-1] = ls;
            else if (k == 9) m_par = ls;
            else begin m_load = 1; m_busy = 0; end
          end
        end
      end
      if (rd) begin m_done = 0; m_perr = 0; m_drv = 0; end
      if (m_load) begin
        m_data = m_bits; m_done = 1;
        m_perr = ($countones({m_bits, m_par}) % 2) == 0;
        if (m_perr && err_en) m_drv = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      chk("R1 model rd_data", rd_data, m_data);
      chk("R4 model par_err", par_err, m_perr);
      chk("R5 model rx_done", rx_done, m_done);
      chk("R6 model drv_low", drv_low, m_drv);
    end
  end

  // skew=1 corrupts the edges of every data and parity bit to probe mid-bit sampling.
  task automatic send(input logic [7:0] b, input bit bad_par, input bit skew);
    logic [9:0] bits;
    bits = {(~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < BIT_CLKS; c++) begin
        @(negedge clk);
        if (skew && i > 0 && (c < 20 || c > 44)) card_drv = ~bits[i];
        else card_drv = bits[i];
      end
    end
    for (int c = 0; c < BIT_CLKS; c++) begin @(negedge clk); card_drv = 1'b1; end
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; card_drv = 1; err_en = 1; rd = 0;
    idle(5);
    chk("R10 rd_data", rd_data, 0);
    chk("R10 flags", {par_err, rx_done, drv_low}, 0);
    @(negedge clk); rst_n = 1;
    idle(20);
    chk("R10 line released", line, 1);

    send(8'hA5, 0, 0);
    chk("R1 data A5", rd_data, 8'hA5);
    chk("R5 done", rx_done, 1);
    chk("R4 good parity", par_err, 0);
    chk("R6 no drive on good parity", drv_low, 0);
    do_read();
    chk("R8 done cleared", rx_done, 0);
    chk("R8 data kept", rd_data, 8'hA5);

    err_en = 0;
    send(8'h00, 0, 0);
    chk("R1 data 00", rd_data, 8'h00);
    chk("R4 good parity 00", par_err, 0);
    do_read();
    send(8'hFF, 0, 0);
    chk("R1 data FF", rd_data, 8'hFF);
    do_read();

    send(8'h5A, 1, 0);
    chk("R4 bad parity flagged", par_err, 1);
    chk("R5 bad frame loaded", rd_data, 8'h5A);
    chk("R7 no drive when disabled", drv_low, 0);
    idle(200);
    chk("R7 still no drive", drv_low, 0);
    do_read();
    chk("R8 perr cleared", par_err, 0);

    err_en = 1;
    send(8'h81, 1, 0);
    chk("R6 drive on bad parity", drv_low, 1);
    chk("R6 wire low", line, 0);
    chk("R5 bad frame data", rd_data, 8'h81);
    send(8'h11, 0, 0);
    chk("R9 data unchanged", rd_data, 8'h81);
    chk("R9 still driving", drv_low, 1);
    chk("R9 done held", rx_done, 1);
    do_read();
    chk("R8 drive released", drv_low, 0);
    chk("R8 perr cleared", par_err, 0);
    chk("R8 done cleared", rx_done, 0);
    chk("R8 data kept 81", rd_data, 8'h81);
    idle(2 * BIT_CLKS);
    chk("R3 release not a start", rx_done, 0);

    @(negedge clk); card_drv = 0;
    idle(3 * TICK_DIV);
    card_drv = 1;
    idle(3 * BIT_CLKS);
    chk("R3 glitch no done", rx_done, 0);
    chk("R3 glitch data kept", rd_data, 8'h81);

    send(8'h6E, 0, 1);
    chk("R2 mid-bit data", rd_data, 8'h6E);
    chk("R2 mid-bit parity", par_err, 0);
    do_read();
    send(8'hC3, 0, 1);
    chk("R2 mid-bit data C3", rd_data, 8'hC3);
    idle(10);
    finish_run();
  end
endmodule